// File: doc/BRIEF.md
# Single-Cycle 12-Bit Microcontroller Core

This block is a small microcontroller core that completes one instruction on every rising clock edge. Instructions are 12 bits wide and come from a 128-word program store. The store is filled through a write port while the core is held stopped. Architectural state is a 7-bit program counter, four 8-bit working registers and a 256-byte data store. There are sixteen 8-bit input locations, presented as one flat 128-bit bus. There are no flags, no carry, no interrupts and no output ports.

The two top instruction bits select one of four classes. Class 01 loads a literal. Class 10 reads the data store. Class 11 writes the data store. Class 00 is split again by bits 7 and 6 into three kinds: a register add, a read from an input location, and a jump to an absolute 7-bit address that is taken when bit 0 of the named register is set.

A program word that was never loaded since the last reset reads as zero, and zero decodes as "r0 := r0 + r0". Reset clears only the program counter and the program store's loaded marks. Working registers and data cells power up undefined and keep their contents through reset and through program loading. Debug outputs expose the program counter and all four registers, so a checker can follow architectural state one instruction at a time.

Top module: `micro12_core`

## Requirements
- R1: While rst_n is low, dbg_pc is 0 immediately, without waiting for a clock edge. A rising edge executes an instruction only if, on each of the two previous rising edges, rst_n was high and pm_we was low. On any other edge the program counter is loaded with 0 and no register or data cell changes.
- R2: When the executed instruction is not a taken jump, the program counter increments by one modulo 128, so address 127 is followed by address 0.
- R3: Word 00dd_00xx_aabb writes (reg a + reg b) mod 256 into reg d, and bits 5:4 (x) have no effect. Register i is shown on dbg_regs[8i+7:8i].
- R4: Word 00dd_01xx_gggg writes input location g into reg d. Location g is taken from gpin[8g+7:8g].
- R5: Word 00rr_1kkk_kkkk sets the program counter to k when bit 0 of reg r is 1. Otherwise the program counter increments as in R2.
- R6: Word 01dd_kkkk_kkkk writes the 8-bit literal k into reg d.
- R7: Word 10dd_nnnn_nnnn writes data cell n into reg d.
- R8: Word 11ss_nnnn_nnnn writes reg s into data cell n. Each instruction reads registers and cells as they stood before its own clock edge.
- R9: After rst_n has been low, every program word not written since then reads as zero, and a zero word executes as r0 := r0 + r0.
- R10: On a rising edge with rst_n high and pm_we high, pm_wdata is stored at program address pm_addr. While the core is held by R1, the registers and data cells keep their values.
- R11: Running the ten-word counting loop (initialise r0..r2, store r1 and r2, poll input 0, increment r2, reload r0, jump back) never takes the program counter above 9, and the loop does reach address 9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, all state changes on rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| pm_we | input | 1 | Program store write enable; also holds the core stopped |
| pm_addr | input | 7 | Program store write address |
| pm_wdata | input | 12 | Program word to store |
| gpin | input | 128 | Sixteen 8-bit input locations, location g at bits 8g+7:8g |
| dbg_pc | output | 7 | Current program counter |
| dbg_regs | output | 32 | Working registers, register i at bits 8i+7:8i |

## Verification
The add is swept with the first operand taking all 256 values while the second follows an unrelated arithmetic sequence, supplied through two input locations. This catches carry-out truncation errors, swapped operand fields, and any effect of the ignored bits. A program that reads every input location in turn, with each location holding a distinct value, tells apart wrong byte selection on the input bus. A data-store program places load-after-store and overwrite-then-reload sequences on a taken and a not-taken jump. It separates stale from fresh cell values and tests both jump polarities. A program of one literal followed by unloaded zero words runs past address 127, which checks zero fill and counter wrap. The ten-word polling loop is driven with a changing input bit, so both branches of its poll are exercised.

// File: rtl/micro12_pkg.sv
package micro12_pkg;

  localparam int INSTR_W = 12;
  localparam int RSEL_W  = 2;
  localparam int PORT_SEL_W = 4;
  localparam int LIT_W   = 8;

  typedef enum logic [2:0] {
    OP_ADD,
    OP_IN,
    OP_JMP,
    OP_LDI,
    OP_LD,
    OP_ST
  } op_e;

  typedef struct packed {
    op_e                   op;
    logic [RSEL_W-1:0]     dst;
    logic [RSEL_W-1:0]     src_a;
    logic [RSEL_W-1:0]     src_b;
    logic [PORT_SEL_W-1:0] port;
    logic [LIT_W-1:0]      lit;
  } dec_t;

endpackage

// File: rtl/micro12_decode.sv
module micro12_decode
  import micro12_pkg::*;
(
  input  logic [INSTR_W-1:0] instr,
  output dec_t               dec
);

  always_comb begin
    dec.op    = OP_ADD;
    dec.dst   = instr[9:8];
    dec.src_a = instr[3:2];
    dec.src_b = instr[1:0];
    dec.port  = instr[3:0];
    dec.lit   = instr[7:0];
    unique case (instr[11:10])
      2'b01:   dec.op = OP_LDI;
      2'b10:   dec.op = OP_LD;
      2'b11:   dec.op = OP_ST;
      default: begin
        if (instr[7])      dec.op = OP_JMP;
        else if (instr[6]) dec.op = OP_IN;
        else               dec.op = OP_ADD;
      end
    endcase
  end

endmodule

// File: rtl/micro12_pmem.sv
module micro12_pmem #(
  parameter  int AW    = 7,
  parameter  int W     = 12,
  localparam int DEPTH = 1 << AW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);

  logic [W-1:0]     words [DEPTH];
  logic [DEPTH-1:0] loaded_q;
  logic [DEPTH-1:0] loaded_d;

  always_comb begin
    loaded_d = loaded_q;
    if (we) loaded_d[waddr] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) loaded_q <= '0;
    else        loaded_q <= loaded_d;
  end

  always_ff @(posedge clk) begin
    if (we) words[waddr] <= wdata;
  end

  assign rdata = loaded_q[raddr] ? words[raddr] : '0;

endmodule

// File: rtl/micro12_regfile.sv
module micro12_regfile #(
  parameter  int N  = 4,
  parameter  int W  = 8,
  localparam int SW = $clog2(N)
) (
  input  logic           clk,
  input  logic           we,
  input  logic [SW-1:0]  waddr,
  input  logic [W-1:0]   wdata,
  output logic [N*W-1:0] flat
);

  logic [W-1:0] q [N];
  logic [N-1:0] en;

  for (genvar i = 0; i < N; i++) begin : g_slot
    assign en[i]             = we && (waddr == SW'(i));
    assign flat[i*W +: W]    = q[i];
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < N; i++) begin
      if (en[i]) q[i] <= wdata;
    end
  end

endmodule

// File: rtl/micro12_dmem.sv
module micro12_dmem #(
  parameter  int AW    = 8,
  parameter  int W     = 8,
  localparam int DEPTH = 1 << AW
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [W-1:0]  wdata,
  output logic [W-1:0]  rdata
);

  logic [W-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) cells[addr] <= wdata;
  end

  assign rdata = cells[addr];

endmodule

// File: rtl/micro12_core.sv
module micro12_core
  import micro12_pkg::*;
#(
  parameter  int PC_W       = 7,
  parameter  int DATA_W     = 8,
  parameter  int DADDR_W    = 8,
  parameter  int NUM_REGS   = 4,
  parameter  int NUM_PORTS  = 16,
  localparam int PORT_BUS_W = NUM_PORTS * DATA_W,
  localparam int REG_BUS_W  = NUM_REGS * DATA_W
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  pm_we,
  input  logic [PC_W-1:0]       pm_addr,
  input  logic [INSTR_W-1:0]    pm_wdata,
  input  logic [PORT_BUS_W-1:0] gpin,
  output logic [PC_W-1:0]       dbg_pc,
  output logic [REG_BUS_W-1:0]  dbg_regs
);

  // run gate: two edges with reset released and no loading
  logic [1:0] run_q;
  logic [1:0] run_d;
  logic       run;

  always_comb run_d = {run_q[0], ~pm_we};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_q <= 2'b00;
    else        run_q <= run_d;
  end

  assign run = &run_q;

  // fetch and decode
  logic [PC_W-1:0]    pc_q;
  logic [PC_W-1:0]    pc_d;
  logic [INSTR_W-1:0] instr;
  dec_t               dec;

  micro12_pmem #(.AW(PC_W), .W(INSTR_W)) u_pmem (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (pm_we),
    .waddr (pm_addr),
    .wdata (pm_wdata),
    .raddr (pc_q),
    .rdata (instr)
  );

  micro12_decode u_dec (
    .instr (instr),
    .dec   (dec)
  );

  // operands
  logic [REG_BUS_W-1:0] regs_flat;
  logic [DATA_W-1:0]    val_a;
  logic [DATA_W-1:0]    val_b;
  logic [DATA_W-1:0]    val_d;
  logic [DATA_W-1:0]    port_val;
  logic [DATA_W-1:0]    dm_rdata;

  always_comb begin
    val_a    = regs_flat[int'(dec.src_a) * DATA_W +: DATA_W];
    val_b    = regs_flat[int'(dec.src_b) * DATA_W +: DATA_W];
    val_d    = regs_flat[int'(dec.dst)   * DATA_W +: DATA_W];
    port_val = gpin[int'(dec.port) * DATA_W +: DATA_W];
  end

  // write-back selection
  logic              rf_we;
  logic [DATA_W-1:0] rf_wdata;
  logic              dm_we;
  logic              jump_taken;

  always_comb begin
    rf_we    = 1'b0;
    rf_wdata = '0;
    unique case (dec.op)
      OP_ADD: begin rf_we = run; rf_wdata = val_a + val_b;         end
      OP_IN:  begin rf_we = run; rf_wdata = port_val;              end
      OP_LDI: begin rf_we = run; rf_wdata = dec.lit[DATA_W-1:0];   end
      OP_LD:  begin rf_we = run; rf_wdata = dm_rdata;              end
      default: ;
    endcase
  end

  assign dm_we      = run && (dec.op == OP_ST);
  assign jump_taken = (dec.op == OP_JMP) && val_d[0];

  micro12_regfile #(.N(NUM_REGS), .W(DATA_W)) u_rf (
    .clk   (clk),
    .we    (rf_we),
    .waddr (dec.dst),
    .wdata (rf_wdata),
    .flat  (regs_flat)
  );

  micro12_dmem #(.AW(DADDR_W), .W(DATA_W)) u_dm (
    .clk   (clk),
    .we    (dm_we),
    .addr  (dec.lit[DADDR_W-1:0]),
    .wdata (val_d),
    .rdata (dm_rdata)
  );

  // program counter
  always_comb begin
    if (!run)            pc_d = '0;
    else if (jump_taken) pc_d = dec.lit[PC_W-1:0];
    else                 pc_d = pc_q + PC_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pc_q <= '0;
    else        pc_q <= pc_d;
  end

  assign dbg_pc   = pc_q;
  assign dbg_regs = regs_flat;

endmodule

// File: rtl/micro12_core_chk.sv
module micro12_core_chk #(
  parameter  int PC_W      = 7,
  parameter  int DATA_W    = 8,
  parameter  int NUM_REGS  = 4,
  parameter  int NUM_PORTS = 16,
  localparam int RB_W      = NUM_REGS * DATA_W,
  localparam int PB_W      = NUM_PORTS * DATA_W
) (
  input logic            clk,
  input logic            rst_n,
  input logic            pm_we,
  input logic            run,
  input logic [11:0]     instr,
  input logic [PC_W-1:0] dbg_pc,
  input logic [RB_W-1:0] dbg_regs,
  input logic [PB_W-1:0] gpin
);

  logic            h_ok;
  logic            h_run;
  logic [11:0]     h_instr;
  logic [PC_W-1:0] h_pc;
  logic [RB_W-1:0] h_regs;
  logic [PB_W-1:0] h_gpin;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) h_ok <= 1'b0;
    else        h_ok <= 1'b1;
  end

  always_ff @(posedge clk) begin
    h_run   <= run;
    h_instr <= instr;
    h_pc    <= dbg_pc;
    h_regs  <= dbg_regs;
    h_gpin  <= gpin;
  end

  function automatic logic [DATA_W-1:0] reg_at(input logic [RB_W-1:0] r, input logic [1:0] s);
    return r[int'(s) * DATA_W +: DATA_W];
  endfunction

  function automatic logic [DATA_W-1:0] port_at(input logic [PB_W-1:0] p, input logic [3:0] s);
    return p[int'(s) * DATA_W +: DATA_W];
  endfunction

  logic h_valid, h_add, h_in, h_jmp, h_ldi, h_cond;
  assign h_valid = h_ok && h_run;
  assign h_add   = (h_instr[11:10] == 2'b00) && !h_instr[7] && !h_instr[6];
  assign h_in    = (h_instr[11:10] == 2'b00) && !h_instr[7] &&  h_instr[6];
  assign h_jmp   = (h_instr[11:10] == 2'b00) &&  h_instr[7];
  assign h_ldi   = (h_instr[11:10] == 2'b01);
  assign h_cond  = |(reg_at(h_regs, h_instr[9:8]) & DATA_W'(1));

  a_r1_load_holds_pc: assert property (@(posedge clk) disable iff (!rst_n)
    pm_we |-> ##2 (dbg_pc == '0));

  a_r2_pc_advance: assert property (@(posedge clk) disable iff (!rst_n)
    (h_valid && !h_jmp) |-> (dbg_pc == PC_W'(h_pc + PC_W'(1))));

  a_r3_add_result: assert property (@(posedge clk) disable iff (!rst_n)
    (h_valid && h_add) |-> (reg_at(dbg_regs, h_instr[9:8]) ==
      DATA_W'(reg_at(h_regs, h_instr[3:2]) + reg_at(h_regs, h_instr[1:0]))));

  a_r4_input_read: assert property (@(posedge clk) disable iff (!rst_n)
    (h_valid && h_in) |-> (reg_at(dbg_regs, h_instr[9:8]) == port_at(h_gpin, h_instr[3:0])));

  a_r5_jump_taken: assert property (@(posedge clk) disable iff (!rst_n)
    (h_valid && h_jmp && h_cond) |-> (dbg_pc == h_instr[PC_W-1:0]));

  a_r5_jump_not_taken: assert property (@(posedge clk) disable iff (!rst_n)
    (h_valid && h_jmp && !h_cond) |-> (dbg_pc == PC_W'(h_pc + PC_W'(1))));

  a_r6_literal_load: assert property (@(posedge clk) disable iff (!rst_n)
    (h_valid && h_ldi) |-> (reg_at(dbg_regs, h_instr[9:8]) == h_instr[DATA_W-1:0]));

endmodule

bind micro12_core micro12_core_chk #(
  .PC_W(PC_W), .DATA_W(DATA_W), .NUM_REGS(NUM_REGS), .NUM_PORTS(NUM_PORTS)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .pm_we    (pm_we),
  .run      (run),
  .instr    (instr),
  .dbg_pc   (dbg_pc),
  .dbg_regs (dbg_regs),
  .gpin     (gpin)
);

// File: tb/micro12_core_test.sv
module micro12_core_test;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         pm_we;
  logic [6:0]   pm_addr;
  logic [11:0]  pm_wdata;
  logic [127:0] gpin;
  logic [6:0]   dbg_pc;
  logic [31:0]  dbg_regs;

  always #2 clk = ~clk;

  micro12_core uut (
    .clk      (clk),
    .rst_n    (rst_n),
    .pm_we    (pm_we),
    .pm_addr  (pm_addr),
    .pm_wdata (pm_wdata),
    .gpin     (gpin),
    .dbg_pc   (dbg_pc),
    .dbg_regs (dbg_regs)
  );

  int nvec = 0;
  int nbad = 0;
  bit cmp_en = 0;

  // ---------------- reference model built from the requirements
  logic [11:0] mprog [128];
  logic [7:0]  mreg  [4];
  bit          mrv   [4];
  logic [7:0]  mdat  [256];
  bit          mdv   [256];
  logic [6:0]  mpc;
  int          okc;
  string       tag = "R1";

  task automatic model_exec();
    logic [11:0] w;
    logic [1:0]  d;
    w = mprog[mpc];
    d = w[9:8];
    mpc = mpc + 7'd1;
    case (w[11:10])
      2'b01: begin mreg[d] = w[7:0]; mrv[d] = 1; tag = "R6"; end
      2'b10: begin mreg[d] = mdat[w[7:0]]; mrv[d] = mdv[w[7:0]]; tag = "R7"; end
      2'b11: begin mdat[w[7:0]] = mreg[d]; mdv[w[7:0]] = mrv[d]; tag = "R8"; end
      default: begin
        if (w[7]) begin
          if (mrv[d] && mreg[d][0]) mpc = w[6:0];
          tag = "R5";
        end else if (w[6]) begin
          mreg[d] = gpin[int'(w[3:0])*8 +: 8]; mrv[d] = 1; tag = "R4";
        end else begin
          mreg[d] = mreg[w[3:2]] + mreg[w[1:0]];
          mrv[d]  = mrv[w[3:2]] && mrv[w[1:0]];
          tag = (w == 12'h000) ? "R9" : "R3";
        end
      end
    endcase
  endtask

  always @(negedge rst_n) begin
    mpc = '0;
    okc = 0;
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      okc = 0;
      mpc = '0;
      for (int i = 0; i < 128; i++) mprog[i] = '0;
    end else begin
      if (okc >= 2) model_exec();
      else begin mpc = '0; tag = "R10"; end
      if (pm_we) mprog[pm_addr] = pm_wdata;
      okc = pm_we ? 0 : ((okc < 2) ? okc + 1 : 2);
    end
  end

  // ---------------- per-cycle comparison
  int         maxpc = 0;
  bit         saw9 = 0;
  bit         wrapped = 0;
  logic [6:0] prevpc = '0;

  always @(negedge clk) begin
    if (cmp_en && rst_n) begin
      nvec++;
      if (dbg_pc !== mpc) begin
        nbad++;
        $display("FAIL %s pc act=%0d exp=%0d", tag, dbg_pc, mpc);
      end
      for (int i = 0; i < 4; i++) begin
        if (mrv[i] && dbg_regs[i*8 +: 8] !== mreg[i]) begin
          nbad++;
          $display("FAIL %s r%0d act=%0h exp=%0h", tag, i, dbg_regs[i*8 +: 8], mreg[i]);
        end
      end
      if (int'(dbg_pc) > maxpc) maxpc = int'(dbg_pc);
      if (dbg_pc == 7'd9) saw9 = 1;
      if (prevpc == 7'd127 && dbg_pc == 7'd0) wrapped = 1;
      prevpc = dbg_pc;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nvec++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] rv(input int i);
    return dbg_regs[i*8 +: 8];
  endfunction

  // ---------------- program loading
  logic [11:0] pb [32];
  int          pn;

  task automatic prog_reset();
    @(negedge clk);
    #1 rst_n = 1'b0;
    #0.5;
    chk(dbg_pc == 7'd0, "R1 async reset", int'(dbg_pc), 0);
    @(negedge clk);
    @(negedge clk);
    chk(dbg_pc == 7'd0, "R1 held in reset", int'(dbg_pc), 0);
    rst_n = 1'b1;
  endtask

  task automatic load_and_go();
    for (int i = 0; i < pn; i++) begin
      pm_we    = 1'b1;
      pm_addr  = 7'(i);
      pm_wdata = pb[i];
      @(negedge clk);
    end
    pm_we = 1'b0;
  endtask

  task automatic wait_pc(input logic [6:0] p);
    while (dbg_pc != p) @(negedge clk);
  endtask

  // ---------------- watchdog
  initial begin
    repeat (150000) @(posedge clk);
    nbad++;
    $display("FAIL watchdog act=running exp=finished");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  // ---------------- stimulus
  initial begin
    rst_n = 1'b0; pm_we = 1'b0; pm_addr = '0; pm_wdata = '0; gpin = '0;
    for (int i = 0; i < 4; i++) mrv[i] = 0;
    for (int i = 0; i < 256; i++) mdv[i] = 0;
    repeat (3) @(negedge clk);
    chk(dbg_pc == 7'd0, "R1 reset state", int'(dbg_pc), 0);
    cmp_en = 1;

    // A: literal then unloaded zero words, run through wrap (R9, R2)
    prog_reset();
    pb[0] = 12'h401; pn = 1;
    load_and_go();
    repeat (2) @(negedge clk);
    chk(dbg_pc == 7'd0, "R1 start delay", int'(dbg_pc), 0);
    repeat (4) @(negedge clk);
    chk(dbg_pc == 7'd4, "R2 count", int'(dbg_pc), 4);
    chk(rv(0) == 8'd8, "R9 zero word doubles r0", int'(rv(0)), 8);
    repeat (130) @(negedge clk);
    chk(wrapped, "R2 wrap 127->0", int'(wrapped), 1);

    // B: add sweep through input locations 3 and 7 (R3, R4, R5)
    prog_reset();
    pb[0] = 12'h401; pb[1] = 12'h143; pb[2] = 12'h247;
    pb[3] = 12'h336; pb[4] = 12'h081; pn = 5;
    load_and_go();
    wait_pc(7'd1);
    for (int i = 0; i < 256; i++) begin
      logic [7:0] a, b;
      a = 8'(i);
      b = 8'((i * 91 + 3) & 255);
      gpin[3*8 +: 8] = a;
      gpin[7*8 +: 8] = b;
      repeat (4) @(negedge clk);
      chk(rv(3) == 8'(a + b), "R3 add sum", int'(rv(3)), int'(8'(a + b)));
      chk(dbg_pc == 7'd1, "R5 taken jump", int'(dbg_pc), 1);
    end

    // E: read every input location (R4)
    for (int g = 0; g < 16; g++) gpin[g*8 +: 8] = 8'(g * 29 + 7);
    prog_reset();
    for (int g = 0; g < 16; g++) pb[g] = {2'b00, 2'(g), 4'b0100, 4'(g)};
    pn = 16;
    load_and_go();
    wait_pc(7'd16);
    for (int r = 0; r < 4; r++)
      chk(rv(r) == 8'((12 + r) * 29 + 7), "R4 input location", int'(rv(r)), int'(8'((12 + r) * 29 + 7)));

    // C: stores and loads, both jump polarities (R6, R7, R8, R5)
    prog_reset();
    pb[0] = 12'h5A5; pb[1] = 12'hDFE; pb[2] = 12'hAFE; pb[3] = 12'h53C;
    pb[4] = 12'hD00; pb[5] = 12'hBFE; pb[6] = 12'h800; pb[7] = 12'h187;
    pb[8] = 12'h288; pn = 9;
    load_and_go();
    repeat (16) @(negedge clk);
    chk(dbg_pc == 7'd8, "R5 not taken then self loop", int'(dbg_pc), 8);
    chk(rv(1) == 8'h3C, "R6 literal", int'(rv(1)), 'h3C);
    chk(rv(2) == 8'hA5, "R7 load after store", int'(rv(2)), 'hA5);
    chk(rv(3) == 8'hA5, "R8 cell kept old value", int'(rv(3)), 'hA5);
    chk(rv(0) == 8'h3C, "R8 second cell", int'(rv(0)), 'h3C);

    // hold by loading without reset (R10)
    pm_we = 1'b1; pm_addr = 7'd20; pm_wdata = 12'h5FF;
    repeat (3) @(negedge clk);
    chk(dbg_pc == 7'd0, "R10 load holds core", int'(dbg_pc), 0);
    chk(rv(1) == 8'h3C, "R10 registers kept", int'(rv(1)), 'h3C);
    pm_we = 1'b0;
    repeat (14) @(negedge clk);
    chk(dbg_pc == 7'd8, "R10 program kept", int'(dbg_pc), 8);

    // D: ten-word counting loop (R11)
    prog_reset();
    pb[0] = 12'h400; pb[1] = 12'h501; pb[2] = 12'h600; pb[3] = 12'hD00;
    pb[4] = 12'hE01; pb[5] = 12'h340; pb[6] = 12'h383; pb[7] = 12'h209;
    pb[8] = 12'h801; pb[9] = 12'h183; pn = 10;
    maxpc = 0; saw9 = 0;
    load_and_go();
    for (int c = 0; c < 400; c++) begin
      gpin[7:0] = 8'((c * 7) >> 3);
      @(negedge clk);
    end
    chk(maxpc <= 9, "R11 pc bound", maxpc, 9);
    chk(saw9, "R11 reaches 9", int'(saw9), 1);

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

endmodule